// File: doc/BRIEF.md
# Small Multi-Function Integer ALU

This block is a purely combinational 4-bit arithmetic logic unit. It takes two operands and a 3-bit operation code. It computes eight results side by side: three bitwise functions, a sum, a difference, a signed less-than test and two logical shifts. An eight-way selector driven by the operation code places one of these results on the output. A zero flag is then derived from that selected output.

Addition and subtraction share one ripple-carry adder. For subtraction the second operand is inverted and the carry-in is forced high. The signed less-than test reuses the same subtraction, so it costs little extra logic.

The block has no clock, no reset and no internal state. A surrounding datapath places it between its own pipeline registers.

Top module: `alu4_core`

## Requirements
- R1: Operation codes 000, 001 and 010 give the bitwise AND, OR and XOR of the two operands.
- R2: Code 011 gives the sum of the operands modulo 16, so 1111 + 0001 yields 0000.
- R3: Code 100 gives the first operand minus the second, in two's complement, modulo 16.
- R4: Code 101 treats both operands as signed 4-bit values. It outputs 0001 when the first is less than the second and 0000 otherwise; for example, -1 versus +1 yields 0001.
- R5: The less-than result stays correct when the internal subtraction overflows; for example, +7 (0111) versus -8 (1000) yields 0000.
- R6: Code 110 shifts the first operand left by the value of the second operand's bits [1:0] (0 to 3 places) and fills the vacated bits with zeros.
- R7: Code 111 shifts the first operand right by the value of the second operand's bits [1:0] and fills the vacated bits with zeros.
- R8: For both shift codes, bits [3:2] of the second operand have no effect on the output.
- R9: The zero flag is 1 exactly when all four output bits are 0; for example, XOR of 0101 and 1010 gives 1111 with the flag at 0.
- R10: The output and the zero flag follow any change of the operands or the operation code without a clock edge, and hold no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand; the value shifted for the shift codes |
| b_i | input | 4 | Second operand; bits [1:0] give the shift amount |
| op_i | input | 3 | Operation code that selects the result |
| result_o | output | 4 | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
Every result is due in the same evaluation as its stimulus, zero clock cycles later, because no register lies between any input and either output. The bench changes the inputs on the falling edge of its pacing clock and samples 1 ns later, well before the next rising edge. A value that needed a clock edge to appear would therefore show up as a mismatch. Every operation code is run over all 256 operand pairs. Seeded random vectors and directed overflow, wrap and shift-amount cases are added on top of that sweep.

// File: rtl/alu4_pkg.sv
// Package alu4_pkg
// Shared operation encodings and sizes for the small ALU.
// Assumes the operation code is exactly three bits wide (eight operations).
package alu4_pkg;
    localparam int OP_BITS = 3;
    localparam int NUM_OPS = 1 << OP_BITS;

    typedef enum logic [OP_BITS-1:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_XOR = 3'd2,
        OP_ADD = 3'd3,
        OP_SUB = 3'd4,
        OP_SLT = 3'd5,
        OP_SLL = 3'd6,
        OP_SRL = 3'd7
    } alu_op_e;
endpackage

// File: rtl/alu4_bitwise.sv
// Module alu4_bitwise
// Computes the three bitwise results (AND, OR, XOR) in parallel.
// Assumes both operands have the same width; the logic is purely combinational.
module alu4_bitwise #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic [WIDTH-1:0] y_and,
    output logic [WIDTH-1:0] y_or,
    output logic [WIDTH-1:0] y_xor
);
    // One gate per bit position for each function.
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            assign y_and[i] = lhs[i] & rhs[i];
            assign y_or[i]  = lhs[i] | rhs[i];
            assign y_xor[i] = lhs[i] ^ rhs[i];
        end
    endgenerate

    // Guard R1: the AND and XOR results must together cover exactly the OR result.
    always_comb begin
        a_r1_or_partition: assert ((y_and | y_xor) == y_or)
            else $error("a_r1_or_partition");
        a_r1_and_xor_disjoint: assert ((y_and & y_xor) == '0)
            else $error("a_r1_and_xor_disjoint");
    end
endmodule

// File: rtl/alu4_addsub.sv
// Module alu4_addsub
// A ripple-carry adder shared by addition and subtraction. When sub is high,
// rhs is inverted and the carry-in is forced to 1, so the sum is lhs - rhs.
// Also reports the signed overflow of the operation.
// Assumes WIDTH >= 2; the logic is purely combinational.
module alu4_addsub #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf
);
    localparam int SMAX = (1 << (WIDTH - 1)) - 1;
    localparam int SMIN = -(1 << (WIDTH - 1));

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] rhs_x;

    assign rhs_x    = rhs ^ {WIDTH{sub}};
    assign carry[0] = sub;

    // Full-adder chain, one stage per bit.
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_fa
            assign sum[i]     = lhs[i] ^ rhs_x[i] ^ carry[i];
            assign carry[i+1] = (lhs[i] & rhs_x[i]) | (carry[i] & (lhs[i] ^ rhs_x[i]));
        end
    endgenerate

    // Signed overflow: the carry into the sign bit differs from the carry out of it.
    assign ovf = carry[WIDTH] ^ carry[WIDTH-1];

    int diff_chk;
    // Guard R2, R3 and R5 against integer arithmetic on the operands.
    always_comb begin
        diff_chk = int'($signed(lhs)) - int'($signed(rhs));
        if (!sub) begin
            a_r2_add_wraps: assert (sum == WIDTH'(lhs + rhs))
                else $error("a_r2_add_wraps");
        end else begin
            a_r3_sub_wraps: assert (sum == WIDTH'(lhs - rhs))
                else $error("a_r3_sub_wraps");
            a_r5_sub_overflow: assert (ovf == ((diff_chk > SMAX) || (diff_chk < SMIN)))
                else $error("a_r5_sub_overflow");
        end
    end
endmodule

// File: rtl/alu4_shift.sv
// Module alu4_shift
// Logarithmic logical shifter that gives the left and right shifts of val by amt.
// Stage k moves the value by 2**k when amt[k] is set. Vacated bits fill with zero.
// Assumes WIDTH is a power of two and SHW = log2(WIDTH).
module alu4_shift #(
    parameter int WIDTH = 4,
    parameter int SHW   = 2
) (
    input  logic [WIDTH-1:0] val,
    input  logic [SHW-1:0]   amt,
    output logic [WIDTH-1:0] shl,
    output logic [WIDTH-1:0] shr
);
    logic [WIDTH-1:0] l_st [SHW+1];
    logic [WIDTH-1:0] r_st [SHW+1];

    assign l_st[0] = val;
    assign r_st[0] = val;

    // One conditional stage per bit of the shift amount.
    genvar k;
    generate
        for (k = 0; k < SHW; k++) begin : g_stage
            assign l_st[k+1] = amt[k] ? (l_st[k] << (1 << k)) : l_st[k];
            assign r_st[k+1] = amt[k] ? (r_st[k] >> (1 << k)) : r_st[k];
        end
    endgenerate

    assign shl = l_st[SHW];
    assign shr = r_st[SHW];

    // Guard R6 and R7 against a single-step shift of the input.
    always_comb begin
        a_r6_left_shift: assert (shl == (val << amt))
            else $error("a_r6_left_shift");
        a_r7_right_shift: assert (shr == (val >> amt))
            else $error("a_r7_right_shift");
    end
endmodule

// File: rtl/alu4_core.sv
// Module alu4_core
// Top of the small ALU. Computes all eight results in parallel, selects one
// by the operation code and derives the zero flag from the selected value.
// Assumes WIDTH is a power of two; there is no clock, reset or state.
module alu4_core
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic [OP_BITS-1:0] op_i,
    output logic [WIDTH-1:0]   result_o,
    output logic               zero_o
);
    localparam int SHW = $clog2(WIDTH);

    logic [WIDTH-1:0] y_and, y_or, y_xor, y_sum, y_shl, y_shr, y_slt;
    logic             use_sub, sub_ovf;
    logic [WIDTH-1:0] cand [NUM_OPS];

    // The less-than test reuses the subtractor, so both codes invert B.
    assign use_sub = (op_i == OP_SUB) || (op_i == OP_SLT);

    alu4_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .lhs  (a_i),
        .rhs  (b_i),
        .y_and(y_and),
        .y_or (y_or),
        .y_xor(y_xor)
    );

    alu4_addsub #(.WIDTH(WIDTH)) u_addsub (
        .lhs(a_i),
        .rhs(b_i),
        .sub(use_sub),
        .sum(y_sum),
        .ovf(sub_ovf)
    );

    alu4_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
        .val(a_i),
        .amt(b_i[SHW-1:0]),
        .shl(y_shl),
        .shr(y_shr)
    );

    // Signed less-than: the sign of the difference, corrected by overflow.
    assign y_slt = {{(WIDTH-1){1'b0}}, y_sum[WIDTH-1] ^ sub_ovf};

    // Candidate table, indexed by the operation code.
    assign cand[OP_AND] = y_and;
    assign cand[OP_OR]  = y_or;
    assign cand[OP_XOR] = y_xor;
    assign cand[OP_ADD] = y_sum;
    assign cand[OP_SUB] = y_sum;
    assign cand[OP_SLT] = y_slt;
    assign cand[OP_SLL] = y_shl;
    assign cand[OP_SRL] = y_shr;

    // Eight-way selector and zero detect.
    always_comb begin
        result_o = cand[op_i];
        zero_o   = ~|result_o;
    end

    // Guard R4, R8 and R9 at the ports.
    always_comb begin
        if (op_i == OP_SLT) begin
            a_r4_slt_signed: assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
                else $error("a_r4_slt_signed");
        end
        if (op_i == OP_SLL) begin
            a_r8_sll_low_amount: assert (result_o == (a_i << b_i[SHW-1:0]))
                else $error("a_r8_sll_low_amount");
        end
        if (op_i == OP_XOR) begin
            a_r9_zero_on_equal: assert (zero_o == (a_i == b_i))
                else $error("a_r9_zero_on_equal");
        end
    end
endmodule

// File: tb/alu4_core_tb.sv
// Bench for alu4_core: exhaustive sweep, seeded random and directed corners,
// compared against a behavioural reference function.
module alu4_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a = '0, b = '0;
    logic [2:0] op = '0;
    logic [3:0] result;
    logic       zero;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz pacing clock

    alu4_core u_dut (
        .a_i(a), .b_i(b), .op_i(op), .result_o(result), .zero_o(zero)
    );

    // Behavioural reference model for every operation code.
    function automatic logic [3:0] ref_alu(input logic [2:0] o, input logic [3:0] x, input logic [3:0] y);
        int sx, sy, amt;
        sx  = (x >= 8) ? int'(x) - 16 : int'(x);
        sy  = (y >= 8) ? int'(y) - 16 : int'(y);
        amt = int'(y) % 4;
        case (o)
            3'd0: return x & y;
            3'd1: return x | y;
            3'd2: return x ^ y;
            3'd3: return 4'((int'(x) + int'(y)) % 16);
            3'd4: return 4'((int'(x) - int'(y) + 16) % 16);
            3'd5: return (sx < sy) ? 4'b0001 : 4'b0000;
            3'd6: return 4'((int'(x) * (1 << amt)) % 16);
            default: return 4'(int'(x) / (1 << amt));
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0, 3'd1, 3'd2: return "R1";
            3'd3: return "R2";
            3'd4: return "R3";
            3'd5: return "R4";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Drive on the falling edge, sample 1 ns later, with no rising edge between (R10).
    task automatic run(input logic [2:0] o, input logic [3:0] x, input logic [3:0] y,
                       input logic [3:0] exp_r, input string tag);
        logic exp_z;
        @(negedge clk);
        op = o; a = x; b = y;
        #1;
        exp_z = (exp_r == 4'd0);
        checks++;
        if (result !== exp_r) begin
            fails++;
            $display("FAIL %s op=%0d a=%b b=%b result=%b expected=%b", tag, o, x, y, result, exp_r);
        end
        checks++;
        if (zero !== exp_z) begin
            fails++;
            $display("FAIL R9 (%s) op=%0d a=%b b=%b zero=%b expected=%b", tag, o, x, y, zero, exp_z);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state check: all-zero inputs give zero output and zero flag set (R9).
        run(3'd0, 4'd0, 4'd0, 4'd0, "R9_reset");
        // Directed corners.
        run(3'd3, 4'b1111, 4'b0001, 4'b0000, "R2_wrap");
        run(3'd4, 4'b0001, 4'b0010, 4'b1111, "R3_negative");
        run(3'd5, 4'b1111, 4'b0001, 4'b0001, "R4_minus1_lt_plus1");
        run(3'd5, 4'b0111, 4'b1000, 4'b0000, "R5_overflow_pos");
        run(3'd5, 4'b1000, 4'b0111, 4'b0001, "R5_overflow_neg");
        run(3'd5, 4'b0011, 4'b0011, 4'b0000, "R4_equal");
        run(3'd2, 4'b0101, 4'b1010, 4'b1111, "R9_xor_nonzero");
        run(3'd2, 4'b1010, 4'b1010, 4'b0000, "R9_xor_zero");
        run(3'd0, 4'b1010, 4'b1100, 4'b1000, "R1_and");
        run(3'd1, 4'b1010, 4'b1100, 4'b1110, "R1_or");
        run(3'd6, 4'b1011, 4'b0011, 4'b1000, "R6_by3");
        run(3'd7, 4'b1011, 4'b0011, 4'b0001, "R7_by3");
        // R8: upper amount bits vary, expectation uses only bits [1:0].
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++) begin
                run(3'd6, 4'(x), 4'(y), ref_alu(3'd6, 4'(x), 4'(y % 4)), "R8_sll");
                run(3'd7, 4'(x), 4'(y), ref_alu(3'd7, 4'(x), 4'(y % 4)), "R8_srl");
            end
        // Exhaustive sweep of every code and operand pair (R10 timing for all).
        for (int o = 0; o < 8; o++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    run(3'(o), 4'(x), 4'(y), ref_alu(3'(o), 4'(x), 4'(y)), tag_of(3'(o)));
        // Seeded random vectors.
        begin
            int unsigned seed;
            seed = $urandom(32'h5EED);
            for (int n = 0; n < 400; n++) begin
                logic [2:0] ro;
                logic [3:0] rx, ry;
                ro = 3'($urandom);
                rx = 4'($urandom);
                ry = 4'($urandom);
                run(ro, rx, ry, ref_alu(ro, rx, ry), tag_of(ro));
            end
            seed = seed + 1;
        end
        done = 1'b1;
        summary();
    end

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end
endmodule